// File: doc/BRIEF.md
# USB Test-Mode Control Register

This block holds the 8-bit test-mode control byte of a dual-role USB controller and the small amount of control logic its bits drive. Software reaches the byte through a simple register port at one fixed address. A role input tells the block whether the controller currently acts as host or as device, and the byte's layout depends on that role.

Three bits do the work. The force-host bit makes the controller take the host role as soon as a session starts, whether or not a peripheral is attached. It keeps that role until the session ends. The force-full-speed bit chooses the bus speed. That speed is captured at each bus reset and is used directly while host mode is forced. The FIFO-access bit asks an external mover to copy the endpoint 0 transmit packet into the endpoint 0 receive FIFO. The request uses a request/done handshake, and the bit clears itself when the copy completes.

Software is expected to set only one test bit at a time. A write that sets several test bits at once raises a sticky flag, and the written values are still stored.

Top module: `usb_tmode_ctrl`

## Requirements
- R1: After a synchronous reset, the register reads 0x00 and every output is 0: `force_host_active`, `host_mode`, `full_speed`, `loop_req` and `multi_err`.
- R2: Bits 4..0 always read 0 and ignore writes. A read at any address other than `REG_OFFSET` returns 0x00. A write at any other address changes nothing.
- R3: In host role (`role_host`=1), bit 7 (force-host) can be written and read back. In device role it reads 0, and writes to it are ignored.
- R4: When bit 7 is set in host role and `session` rises, `force_host_active` and `host_mode` are 1 from the next clock, whatever `peer_attached` is.
- R5: Once `force_host_active` is set, it stays 1 while `session` stays 1, even if `peer_attached` drops. It goes to 0 on the clock after `session` is seen low.
- R6: If bit 7 is still set when `session` rises again, forced host mode is entered again.
- R7: Bit 5 (force-full-speed) is read/write. On each clock with `bus_reset`=1, its value is captured. Outside forced host mode, `full_speed` shows the captured value (1 means full speed, 0 means low speed) and does not follow writes to bit 5 between bus resets.
- R8: While `force_host_active`=1, `full_speed` equals bit 5 directly.
- R9: Bit 6 (FIFO-access) is write-1-to-set. Writing 1 raises `loop_req`, and bit 6 reads back as 1. Writing 0 to it has no effect.
- R10: While a copy is pending, further 1-writes to bit 6 are ignored. When `loop_done` is 1 during a pending copy, bit 6 and `loop_req` are 0 from the next clock. After that, a new 1-write starts a new request.
- R11: A write that sets more than one of bits 7, 6 and 5 sets `multi_err`. Bit 7 counts only in host role. `multi_err` stays 1 until reset, and the written bits are stored anyway.
- R12: Without forcing, `host_mode` = `role_host` AND `session` AND `peer_attached`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| role_host | input | 1 | 1 = controller in host role, 0 = device role |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational) |
| session | input | 1 | Session bit |
| peer_attached | input | 1 | Peripheral-present indication from line sensing |
| bus_reset | input | 1 | USB bus reset seen |
| loop_done | input | 1 | FIFO mover reports copy finished |
| force_host_active | output | 1 | Forced host mode in effect |
| host_mode | output | 1 | Controller acts as host |
| full_speed | output | 1 | 1 = full speed, 0 = low speed |
| loop_req | output | 1 | Request to copy the EP0 transmit packet to the EP0 receive FIFO |
| multi_err | output | 1 | Sticky flag: several test bits written at once |

## Verification
The assertions check several rules on every cycle: a pending loopback request holds until done and then drops; forced host mode persists through a session and drops when the session ends; the captured speed changes only at a bus reset; and the error flag is sticky. Other behaviours only show up in the bench's scenarios. These are the role-dependent readback of bit 7, re-entry of forced host mode on a second session rise, forced mode ignoring `peer_attached`, and `full_speed` switching to the live bit 5 under forcing. The scenarios also show that write-0 on bit 6, reserved bits and writes at other addresses leave the readback unchanged.

// File: rtl/usb_tmode_pkg.sv
package usb_tmode_pkg;

    localparam int REG_W  = 8;
    localparam int BIT_FH = 7;
    localparam int BIT_FA = 6;
    localparam int BIT_FS = 5;

    typedef struct packed {
        logic force_host;
        logic fifo_copy;
        logic force_fs;
    } tmode_bits_t;

    function automatic logic [1:0] count_test_bits(input logic fh, input logic fa, input logic fs);
        return {1'b0, fh} + {1'b0, fa} + {1'b0, fs};
    endfunction

    function automatic logic [REG_W-1:0] pack_readback(input tmode_bits_t b, input logic host);
        logic [REG_W-1:0] v;
        v = '0;
        v[BIT_FH] = b.force_host & host;
        v[BIT_FA] = b.fifo_copy;
        v[BIT_FS] = b.force_fs;
        return v;
    endfunction

endpackage

// File: rtl/tmode_regs.sv
module tmode_regs
    import usb_tmode_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_hit,
    input  logic [REG_W-1:0] wdata,
    input  logic             role_host,
    input  logic             loop_done,
    output tmode_bits_t      bits,
    output logic             multi_err
);
    tmode_bits_t bits_q;
    logic        err_q;
    logic        fh_wr;

    assign fh_wr = wdata[BIT_FH] & role_host;

    always_ff @(posedge clk) begin
        if (rst) begin
            bits_q <= '0;
            err_q  <= 1'b0;
        end else begin
            if (wr_hit) begin
                if (role_host)
                    bits_q.force_host <= wdata[BIT_FH];
                bits_q.force_fs <= wdata[BIT_FS];
                if (count_test_bits(fh_wr, wdata[BIT_FA], wdata[BIT_FS]) > 2'd1)
                    err_q <= 1'b1;
            end
            if (bits_q.fifo_copy) begin
                if (loop_done)
                    bits_q.fifo_copy <= 1'b0;
            end else if (wr_hit && wdata[BIT_FA]) begin
                bits_q.fifo_copy <= 1'b1;
            end
        end
    end

    assign bits      = bits_q;
    assign multi_err = err_q;

    AST_LOOP_HOLD:  assert property (@(posedge clk) disable iff (rst)
        bits_q.fifo_copy && !loop_done |=> bits_q.fifo_copy); // R10
    AST_LOOP_CLEAR: assert property (@(posedge clk) disable iff (rst)
        bits_q.fifo_copy && loop_done |=> !bits_q.fifo_copy); // R10
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q); // R11
endmodule

// File: rtl/tmode_force_host.sv
module tmode_force_host (
    input  logic clk,
    input  logic rst,
    input  logic force_req,
    input  logic session,
    output logic active
);
    logic sess_q;
    logic act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sess_q <= 1'b0;
            act_q  <= 1'b0;
        end else begin
            sess_q <= session;
            if (!session)
                act_q <= 1'b0;
            else if (!sess_q && force_req)
                act_q <= 1'b1;
        end
    end

    assign active = act_q;

    AST_FORCE_PERSIST: assert property (@(posedge clk) disable iff (rst)
        act_q && session |=> act_q); // R5
    AST_FORCE_DROP:    assert property (@(posedge clk) disable iff (rst)
        !session |=> !act_q); // R5
endmodule

// File: rtl/tmode_speed.sv
module tmode_speed (
    input  logic clk,
    input  logic rst,
    input  logic bus_reset,
    input  logic force_fs,
    input  logic forced,
    output logic full_speed
);
    logic spd_q;

    always_ff @(posedge clk) begin
        if (rst)
            spd_q <= 1'b0;
        else if (bus_reset)
            spd_q <= force_fs;
    end

    assign full_speed = forced ? force_fs : spd_q;

    AST_SPEED_STABLE: assert property (@(posedge clk) disable iff (rst)
        !bus_reset |=> $stable(spd_q)); // R7
endmodule

// File: rtl/usb_tmode_ctrl.sv
module usb_tmode_ctrl
    import usb_tmode_pkg::*;
#(
    parameter int              ADDR_W     = 4,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 4'hF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              role_host,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              session,
    input  logic              peer_attached,
    input  logic              bus_reset,
    input  logic              loop_done,
    output logic              force_host_active,
    output logic              host_mode,
    output logic              full_speed,
    output logic              loop_req,
    output logic              multi_err
);
    logic        hit;
    logic        wr_hit;
    tmode_bits_t bits;
    logic        forced;

    assign hit    = (reg_addr == REG_OFFSET);
    assign wr_hit = hit & reg_wr;

    tmode_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_hit    (wr_hit),
        .wdata     (reg_wdata),
        .role_host (role_host),
        .loop_done (loop_done),
        .bits      (bits),
        .multi_err (multi_err)
    );

    tmode_force_host u_force (
        .clk       (clk),
        .rst       (rst),
        .force_req (bits.force_host & role_host),
        .session   (session),
        .active    (forced)
    );

    tmode_speed u_speed (
        .clk        (clk),
        .rst        (rst),
        .bus_reset  (bus_reset),
        .force_fs   (bits.force_fs),
        .forced     (forced),
        .full_speed (full_speed)
    );

    assign reg_rdata         = hit ? pack_readback(bits, role_host) : '0;
    assign force_host_active = forced;
    assign host_mode         = forced | (role_host & session & peer_attached);
    assign loop_req          = bits.fifo_copy;

    AST_FORCED_IS_HOST: assert property (@(posedge clk) disable iff (rst)
        force_host_active |-> host_mode); // R4
endmodule

// File: tb/tb_usb_tmode_ctrl.sv
module tb_usb_tmode_ctrl;
    localparam int  CLK_PERIOD = 10;
    localparam logic [3:0] OFF = 4'hF;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       role_host = 1'b1;
    logic [3:0] reg_addr = OFF;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       session = 1'b0, peer_attached = 1'b0, bus_reset = 1'b0, loop_done = 1'b0;
    logic       force_host_active, host_mode, full_speed, loop_req, multi_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    usb_tmode_ctrl dut (
        .clk(clk), .rst(rst), .role_host(role_host), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .session(session), .peer_attached(peer_attached), .bus_reset(bus_reset),
        .loop_done(loop_done), .force_host_active(force_host_active),
        .host_mode(host_mode), .full_speed(full_speed), .loop_req(loop_req),
        .multi_err(multi_err)
    );

    typedef struct {
        int         sig;
        logic [7:0] exp;
        string      tag;
    } exp_item_t;

    exp_item_t sb_q[$];
    event      chk_ev;
    int        n_checks = 0;
    int        n_errors = 0;
    bit        finished = 0;

    function automatic logic [7:0] observe(input int sig);
        case (sig)
            0: return reg_rdata;
            1: return {7'd0, force_host_active};
            2: return {7'd0, host_mode};
            3: return {7'd0, full_speed};
            4: return {7'd0, loop_req};
            default: return {7'd0, multi_err};
        endcase
    endfunction

    initial begin
        forever begin
            @(chk_ev);
            while (sb_q.size() > 0) begin
                exp_item_t it;
                logic [7:0] act;
                it  = sb_q.pop_front();
                act = observe(it.sig);
                n_checks++;
                if (act !== it.exp) begin
                    n_errors++;
                    $display("FAIL %s: sig%0d actual=%h expected=%h", it.tag, it.sig, act, it.exp);
                end
            end
        end
    end

    task automatic expect_sig(input int sig, input logic [7:0] exp, input string tag);
        exp_item_t it;
        it.sig = sig; it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic flush();
        -> chk_ev;
        #1;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0; reg_addr = OFF;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst = 1'b0;
        #1;
        // R1 reset state
        expect_sig(0, 8'h00, "R1"); expect_sig(1, 0, "R1"); expect_sig(2, 0, "R1");
        expect_sig(3, 0, "R1"); expect_sig(4, 0, "R1"); expect_sig(5, 0, "R1");
        flush();

        // R2 reserved bits and foreign address
        wr(OFF, 8'h1F);
        expect_sig(0, 8'h00, "R2 reserved"); flush();
        wr(4'h3, 8'h20);
        expect_sig(0, 8'h00, "R2 other addr write"); flush();
        reg_addr = 4'h3; #1;
        expect_sig(0, 8'h00, "R2 other addr read"); flush();
        reg_addr = OFF; #1;

        // R3 role dependent bit 7
        wr(OFF, 8'h80);
        expect_sig(0, 8'h80, "R3 host rw"); flush();
        role_host = 1'b0; #1;
        expect_sig(0, 8'h00, "R3 device reads 0"); flush();
        role_host = 1'b1;
        wr(OFF, 8'h00);
        role_host = 1'b0;
        wr(OFF, 8'h80);
        role_host = 1'b1; #1;
        expect_sig(0, 8'h00, "R3 device write ignored"); flush();

        // R12 unforced host mode
        session = 1'b1; peer_attached = 1'b1; tick();
        expect_sig(2, 1, "R12 host attached"); expect_sig(1, 0, "R12 not forced"); flush();
        peer_attached = 1'b0; #1;
        expect_sig(2, 0, "R12 detached"); flush();
        session = 1'b0; tick();

        // R4 forced entry without peer
        wr(OFF, 8'h80);
        session = 1'b1; tick();
        expect_sig(1, 1, "R4 forced"); expect_sig(2, 1, "R4 host_mode"); flush();
        // R5 persistence over attach/detach
        peer_attached = 1'b1; tick();
        peer_attached = 1'b0; tick();
        expect_sig(1, 1, "R5 persist"); expect_sig(2, 1, "R5 host_mode"); flush();
        // R8 speed follows bit 5 while forced, R11 multi-bit write
        expect_sig(5, 0, "R11 no err yet"); flush();
        wr(OFF, 8'hA0);
        expect_sig(3, 1, "R8 fs live"); expect_sig(5, 1, "R11 err set");
        expect_sig(0, 8'hA0, "R11 values stored"); flush();
        wr(OFF, 8'h80);
        expect_sig(3, 0, "R8 ls live"); expect_sig(5, 1, "R11 sticky"); flush();
        session = 1'b0; tick();
        expect_sig(1, 0, "R5 drop"); expect_sig(2, 0, "R5 host_mode drop"); flush();
        // R6 re-entry
        session = 1'b1; tick();
        expect_sig(1, 1, "R6 re-entry"); flush();
        session = 1'b0; tick();
        expect_sig(1, 0, "R6 drop"); flush();

        // R7 speed latched at bus reset
        wr(OFF, 8'h20);
        expect_sig(3, 0, "R7 no reset yet"); flush();
        bus_reset = 1'b1; tick(); bus_reset = 1'b0;
        expect_sig(3, 1, "R7 latched fs"); flush();
        wr(OFF, 8'h00);
        expect_sig(3, 1, "R7 held"); flush();
        bus_reset = 1'b1; tick(); bus_reset = 1'b0;
        expect_sig(3, 0, "R7 latched ls"); flush();

        // R9 write-1-to-set loopback
        wr(OFF, 8'h00);
        expect_sig(4, 0, "R9 write0 idle"); flush();
        wr(OFF, 8'h40);
        expect_sig(4, 1, "R9 set"); expect_sig(0, 8'h40, "R9 readback"); flush();
        wr(OFF, 8'h00);
        expect_sig(4, 1, "R9 write0 no effect"); expect_sig(0, 8'h40, "R9 readback kept"); flush();
        // R10 write while pending with done same cycle: cleared, write ignored
        loop_done = 1'b1;
        wr(OFF, 8'h40);
        loop_done = 1'b0;
        expect_sig(4, 0, "R10 cleared"); expect_sig(0, 8'h00, "R10 readback 0"); flush();
        wr(OFF, 8'h40);
        expect_sig(4, 1, "R10 new request"); flush();
        tick(); tick();
        expect_sig(4, 1, "R10 waits for done"); flush();
        loop_done = 1'b1; tick(); loop_done = 1'b0;
        expect_sig(4, 0, "R10 done clears"); flush();

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule